// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block translates virtual addresses into physical addresses for a core that works with 4 KB pages. The upper part of the virtual address is the virtual page number. It is compared in parallel against the tag of every valid entry, so no part of the address selects an entry. On a match, the stored physical page number is joined to the low offset bits, which pass through unchanged. A store that matches an entry marks that entry as modified. A miss is reported to the requester, and a separate refill port installs the missing translation.

A request is registered and answered one cycle later. The answer is held in a small response state machine with three states. `RSP_IDLE` means no answer is presented. `RSP_HIT` presents a translated address. `RSP_MISS` reports a missing translation. From every state, the next state is `RSP_HIT` when a request arrives that matches an entry, `RSP_MISS` when a request arrives that matches none, and `RSP_IDLE` when no request arrives or a flush is applied. The refill port chooses its slot in a fixed order. An entry that already holds the same page number comes first. Next is the lowest-numbered empty slot. Last is a round-robin eviction pointer.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is invalid, no response is presented, and any lookup misses.
- R2: A request accepted in cycle N produces `rsp_valid` in cycle N+1 with exactly one of `rsp_hit`/`rsp_miss` set. A cycle without an accepted request produces `rsp_valid` low in the next cycle.
- R3: On a hit, `rsp_paddr[31:12]` is the stored physical page number and `rsp_paddr[11:0]` equals `req_vaddr[11:0]` of the request. The page number is `req_vaddr[31:12]`.
- R4: On a miss, `rsp_paddr` is zero and `rsp_dirty` is zero.
- R5: A store (`req_store`=1) that hits sets that entry's modified bit, and a load hit leaves it unchanged. On a hit, `rsp_dirty` reports the bit as it stands after the access.
- R6: A refill writes page number, frame number and valid and clears the modified bit. A request in the same cycle as the refill sees the contents from before the refill, and later requests see the new entry.
- R7: A refill whose page number is already present overwrites that entry. It never creates two valid entries with the same tag, and the other entries are left untouched.
- R8: A refill of a new page number takes the lowest-indexed invalid entry. When all entries are valid, it evicts the entry under a round-robin pointer. The pointer starts at 0, advances by one on each such eviction, and wraps after the last entry.
- R9: `flush` invalidates all entries in one cycle. A request, refill or modified-bit update presented in the flush cycle is discarded.
- R10: When a refill and a store hit target the same entry in one cycle, the refill wins and the modified bit ends cleared. The store's own response still reports the old frame with `rsp_dirty`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all entries |
| req_valid | input | 1 | Lookup request |
| req_store | input | 1 | Request is a store |
| req_vaddr | input | 32 | Virtual address |
| refill_valid | input | 1 | Install a translation |
| refill_vpn | input | 20 | Page number to install |
| refill_ppn | input | 20 | Frame number to install |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | Translation missing |
| rsp_dirty | output | 1 | Modified bit of the hit entry |
| rsp_paddr | output | 32 | Physical address on hit, zero otherwise |

## Verification
The checker relies on the refill port being the only way entries are created, so the lookup match vector is assumed never to have more than one bit set. It also assumes that requests and flushes are sampled at clean edges, with `rst_n` held until inputs are stable. The stimulus changes every input on the falling edge only. It installs translations only through the refill port. It deliberately overlaps refill, store hit, request and flush in the same cycle, so that the ordering rules are exercised without ever breaking the single-match assumption.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    // Response phase presented on the output side
    typedef enum logic [1:0] {
        RSP_IDLE = 2'd0,
        RSP_HIT  = 2'd1,
        RSP_MISS = 2'd2
    } rsp_state_e;

endpackage

// File: rtl/xlat_onehot_enc.sv
module xlat_onehot_enc #(
    parameter int N = 64,
    parameter int W = 6
) (
    input  logic [N-1:0] vec,
    output logic [W-1:0] idx,
    output logic         any
);

    // OR-reduction encoder; input is expected to carry at most one bit
    always_comb begin
        idx = '0;
        any = |vec;
        for (int i = 0; i < N; i++) begin
            if (vec[i]) begin
                idx = idx | W'(i);
            end
        end
    end

endmodule

// File: rtl/xlat_entry_array.sv
module xlat_entry_array #(
    parameter int ENTRIES = 64,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20,
    parameter int IDX_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic [VPN_W-1:0]   lk_vpn,
    input  logic [VPN_W-1:0]   rf_vpn,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [PPN_W-1:0]   wr_ppn,
    input  logic               dset_en,
    input  logic [IDX_W-1:0]   dset_idx,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [ENTRIES-1:0] lk_match,
    output logic [ENTRIES-1:0] rf_match,
    output logic [ENTRIES-1:0] valid_vec,
    output logic [PPN_W-1:0]   rd_ppn,
    output logic               rd_dirty
);

    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] dirty_q;
    logic [VPN_W-1:0]   tag_q [ENTRIES];
    logic [PPN_W-1:0]   ppn_q [ENTRIES];

    // Status bits: flush over refill over modified-bit update
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (flush) begin
                    valid_q[i] <= 1'b0;
                end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                    valid_q[i] <= 1'b1;
                    dirty_q[i] <= 1'b0;
                end else if (dset_en && (dset_idx == IDX_W'(i))) begin
                    dirty_q[i] <= 1'b1;
                end
            end
        end
    end

    // Payload storage carries no reset
    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (wr_en && !flush && (wr_idx == IDX_W'(i))) begin
                tag_q[i] <= rf_vpn;
                ppn_q[i] <= wr_ppn;
            end
        end
    end

    // One comparator pair per entry
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign lk_match[g] = valid_q[g] && (tag_q[g] == lk_vpn);
        assign rf_match[g] = valid_q[g] && (tag_q[g] == rf_vpn);
    end

    assign valid_vec = valid_q;
    assign rd_ppn    = ppn_q[rd_idx];
    assign rd_dirty  = dirty_q[rd_idx];

endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fire,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic [ENTRIES-1:0] rf_match,
    output logic [IDX_W-1:0]   victim_idx
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] same_idx;
    logic             same_any;
    logic [IDX_W-1:0] free_idx;
    logic             free_any;

    xlat_onehot_enc #(.N(ENTRIES), .W(IDX_W)) u_same_enc (
        .vec (rf_match),
        .idx (same_idx),
        .any (same_any)
    );

    // Lowest-indexed empty slot
    always_comb begin
        free_idx = '0;
        free_any = ~&valid_vec;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                free_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        if (same_any) begin
            victim_idx = same_idx;
        end else if (free_any) begin
            victim_idx = free_idx;
        end else begin
            victim_idx = rr_q;
        end
    end

    // Pointer moves only when it actually chose the slot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (fire && !same_any && !free_any) begin
            rr_q <= (rr_q == LAST_IDX) ? '0 : rr_q + 1'b1;
        end
    end

endmodule

// File: rtl/xlat_resp_fsm.sv
module xlat_resp_fsm
    import xlat_pkg::*;
#(
    parameter int PPN_W = 20,
    parameter int OFF_W = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_fire,
    input  logic                   req_store,
    input  logic                   lk_any,
    input  logic [PPN_W-1:0]       lk_ppn,
    input  logic                   lk_dirty,
    input  logic [OFF_W-1:0]       lk_off,
    output logic                   rsp_valid,
    output logic                   rsp_hit,
    output logic                   rsp_miss,
    output logic                   rsp_dirty,
    output logic [PPN_W+OFF_W-1:0] rsp_paddr
);

    rsp_state_e                state_q;
    rsp_state_e                state_d;
    logic [PPN_W+OFF_W-1:0]    paddr_q;
    logic                      dirty_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = RSP_IDLE;
        unique case (state_q)
            RSP_IDLE, RSP_HIT, RSP_MISS: begin
                if (req_fire) begin
                    state_d = lk_any ? RSP_HIT : RSP_MISS;
                end else begin
                    state_d = RSP_IDLE;
                end
            end
            default: state_d = RSP_IDLE;
        endcase
    end

    // Response payload captured with the transition into RSP_HIT
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            paddr_q <= '0;
            dirty_q <= 1'b0;
        end else if (req_fire && lk_any) begin
            paddr_q <= {lk_ppn, lk_off};
            dirty_q <= lk_dirty | req_store;
        end
    end

    // Outputs
    always_comb begin
        rsp_valid = 1'b0;
        rsp_hit   = 1'b0;
        rsp_miss  = 1'b0;
        rsp_dirty = 1'b0;
        rsp_paddr = '0;
        unique case (state_q)
            RSP_IDLE: ;
            RSP_HIT: begin
                rsp_valid = 1'b1;
                rsp_hit   = 1'b1;
                rsp_dirty = dirty_q;
                rsp_paddr = paddr_q;
            end
            RSP_MISS: begin
                rsp_valid = 1'b1;
                rsp_miss  = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
    parameter int VA_W    = 32,
    parameter int OFF_W   = 12,
    parameter int PA_W    = 32,
    parameter int ENTRIES = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flush,
    input  logic                  req_valid,
    input  logic                  req_store,
    input  logic [VA_W-1:0]       req_vaddr,
    input  logic                  refill_valid,
    input  logic [VA_W-OFF_W-1:0] refill_vpn,
    input  logic [PA_W-OFF_W-1:0] refill_ppn,
    output logic                  rsp_valid,
    output logic                  rsp_hit,
    output logic                  rsp_miss,
    output logic                  rsp_dirty,
    output logic [PA_W-1:0]       rsp_paddr
);

    localparam int VPN_W = VA_W - OFF_W;
    localparam int PPN_W = PA_W - OFF_W;
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic               req_fire;
    logic               wr_en;
    logic [VPN_W-1:0]   lk_vpn;
    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] rf_match;
    logic [ENTRIES-1:0] valid_vec;
    logic [IDX_W-1:0]   lk_idx;
    logic               lk_any;
    logic [IDX_W-1:0]   victim_idx;
    logic [PPN_W-1:0]   lk_ppn;
    logic               lk_dirty;
    logic               dset_en;

    assign req_fire = req_valid && !flush;
    assign wr_en    = refill_valid && !flush;
    assign lk_vpn   = req_vaddr[VA_W-1:OFF_W];
    assign dset_en  = req_fire && req_store && lk_any;

    xlat_entry_array #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .PPN_W   (PPN_W),
        .IDX_W   (IDX_W)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .lk_vpn    (lk_vpn),
        .rf_vpn    (refill_vpn),
        .wr_en     (wr_en),
        .wr_idx    (victim_idx),
        .wr_ppn    (refill_ppn),
        .dset_en   (dset_en),
        .dset_idx  (lk_idx),
        .rd_idx    (lk_idx),
        .lk_match  (lk_match),
        .rf_match  (rf_match),
        .valid_vec (valid_vec),
        .rd_ppn    (lk_ppn),
        .rd_dirty  (lk_dirty)
    );

    xlat_onehot_enc #(.N(ENTRIES), .W(IDX_W)) u_lk_enc (
        .vec (lk_match),
        .idx (lk_idx),
        .any (lk_any)
    );

    xlat_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (wr_en),
        .valid_vec  (valid_vec),
        .rf_match   (rf_match),
        .victim_idx (victim_idx)
    );

    xlat_resp_fsm #(.PPN_W(PPN_W), .OFF_W(OFF_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_fire  (req_fire),
        .req_store (req_store),
        .lk_any    (lk_any),
        .lk_ppn    (lk_ppn),
        .lk_dirty  (lk_dirty),
        .lk_off    (req_vaddr[OFF_W-1:0]),
        .rsp_valid (rsp_valid),
        .rsp_hit   (rsp_hit),
        .rsp_miss  (rsp_miss),
        .rsp_dirty (rsp_dirty),
        .rsp_paddr (rsp_paddr)
    );

endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
    parameter int VA_W    = 32,
    parameter int OFF_W   = 12,
    parameter int PA_W    = 32,
    parameter int ENTRIES = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               flush,
    input logic               req_valid,
    input logic [VA_W-1:0]    req_vaddr,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic               rsp_miss,
    input logic               rsp_dirty,
    input logic [PA_W-1:0]    rsp_paddr,
    input logic [ENTRIES-1:0] lk_match,
    input logic [ENTRIES-1:0] valid_vec
);

    // R7
    single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));

    // R2
    hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_hit && rsp_miss) && (rsp_valid == (rsp_hit || rsp_miss)));

    // R2
    answer_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !flush) |=> rsp_valid);

    // R9
    no_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !flush) |=> !rsp_valid);

    // R4
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (rsp_paddr == '0 && !rsp_dirty));

    // R3
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !flush) |=> (!rsp_hit || rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0])));

    // R9
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_vec == '0));

endmodule

bind xlat_cache xlat_cache_chk #(
    .VA_W    (VA_W),
    .OFF_W   (OFF_W),
    .PA_W    (PA_W),
    .ENTRIES (ENTRIES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .req_valid (req_valid),
    .req_vaddr (req_vaddr),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_miss  (rsp_miss),
    .rsp_dirty (rsp_dirty),
    .rsp_paddr (rsp_paddr),
    .lk_match  (lk_match),
    .valid_vec (valid_vec)
);

// File: tb/test_xlat_cache.sv
`timescale 1ns/1ps
module test_xlat_cache;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_store = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        refill_valid = 1'b0;
    logic [19:0] refill_vpn = '0;
    logic [19:0] refill_ppn = '0;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_dirty;
    logic [31:0] rsp_paddr;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    xlat_cache i_xlat_cache (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .req_valid(req_valid), .req_store(req_store), .req_vaddr(req_vaddr),
        .refill_valid(refill_valid), .refill_vpn(refill_vpn), .refill_ppn(refill_ppn),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_dirty(rsp_dirty), .rsp_paddr(rsp_paddr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Request at a falling edge, answer read at the next falling edge
    task automatic lookup(input logic [19:0] vpn, input logic [11:0] off, input logic st);
        @(negedge clk);
        req_valid = 1'b1; req_store = st; req_vaddr = {vpn, off};
        @(negedge clk);
        req_valid = 1'b0; req_store = 1'b0;
    endtask

    task automatic refill(input logic [19:0] vpn, input logic [19:0] ppn);
        @(negedge clk);
        refill_valid = 1'b1; refill_vpn = vpn; refill_ppn = ppn;
        @(negedge clk);
        refill_valid = 1'b0;
    endtask

    task automatic expect_hit(input string tag, input logic [19:0] vpn, input logic [11:0] off,
                              input logic st, input logic [19:0] ppn, input logic drt);
        lookup(vpn, off, st);
        chk({tag, " hit"}, {31'd0, rsp_hit}, 32'd1);
        chk({tag, " paddr"}, rsp_paddr, {ppn, off});
        chk({tag, " dirty"}, {31'd0, rsp_dirty}, {31'd0, drt});
    endtask

    task automatic expect_miss(input string tag, input logic [19:0] vpn);
        lookup(vpn, 12'h5A5, 1'b0);
        chk({tag, " miss"}, {31'd0, rsp_miss}, 32'd1);
        chk({tag, " paddr"}, rsp_paddr, 32'd0);
        chk({tag, " dirty"}, {31'd0, rsp_dirty}, 32'd0);
    endtask

    task automatic t_reset();
        chk("R1 idle after reset", {31'd0, rsp_valid}, 32'd0);
        expect_miss("R1 empty", 20'h00005);
        @(negedge clk);
        chk("R2 no request", {31'd0, rsp_valid}, 32'd0);
    endtask

    task automatic t_basic();
        refill(20'h12345, 20'h0ABCD);
        expect_hit("R3 mid offset", 20'h12345, 12'h7FF, 1'b0, 20'h0ABCD, 1'b0);
        expect_hit("R3 low offset", 20'h12345, 12'h000, 1'b0, 20'h0ABCD, 1'b0);
        expect_hit("R3 high offset", 20'h12345, 12'hFFF, 1'b0, 20'h0ABCD, 1'b0);
        expect_miss("R4 other page", 20'h12344);
    endtask

    task automatic t_dirty();
        expect_hit("R5 load keeps clean", 20'h12345, 12'h010, 1'b0, 20'h0ABCD, 1'b0);
        expect_hit("R5 store sets", 20'h12345, 12'h020, 1'b1, 20'h0ABCD, 1'b1);
        expect_hit("R5 load sees set", 20'h12345, 12'h030, 1'b0, 20'h0ABCD, 1'b1);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        refill_valid = 1'b1; refill_vpn = 20'h0BEEF; refill_ppn = 20'h00777;
        req_valid = 1'b1; req_store = 1'b0; req_vaddr = {20'h0BEEF, 12'h123};
        @(negedge clk);
        refill_valid = 1'b0; req_valid = 1'b0;
        chk("R6 same-cycle sees old", {31'd0, rsp_miss}, 32'd1);
        expect_hit("R6 next sees new", 20'h0BEEF, 12'h456, 1'b0, 20'h00777, 1'b0);
    endtask

    task automatic t_overwrite();
        refill(20'h12345, 20'h11111);
        expect_hit("R7 overwrite clears dirty", 20'h12345, 12'h001, 1'b0, 20'h11111, 1'b0);
        expect_hit("R7 neighbour intact", 20'h0BEEF, 12'h002, 1'b0, 20'h00777, 1'b0);
    endtask

    task automatic t_race();
        @(negedge clk);
        refill_valid = 1'b1; refill_vpn = 20'h12345; refill_ppn = 20'h22222;
        req_valid = 1'b1; req_store = 1'b1; req_vaddr = {20'h12345, 12'h0F0};
        @(negedge clk);
        refill_valid = 1'b0; req_valid = 1'b0; req_store = 1'b0;
        chk("R10 store answer old frame", rsp_paddr, {20'h11111, 12'h0F0});
        chk("R10 store answer dirty", {31'd0, rsp_dirty}, 32'd1);
        expect_hit("R10 refill wins", 20'h12345, 12'h0F1, 1'b0, 20'h22222, 1'b0);
    endtask

    task automatic t_flush();
        @(negedge clk);
        flush = 1'b1;
        req_valid = 1'b1; req_store = 1'b1; req_vaddr = {20'h12345, 12'h000};
        refill_valid = 1'b1; refill_vpn = 20'h0C0DE; refill_ppn = 20'h00001;
        @(negedge clk);
        flush = 1'b0; req_valid = 1'b0; req_store = 1'b0; refill_valid = 1'b0;
        chk("R9 request dropped", {31'd0, rsp_valid}, 32'd0);
        expect_miss("R9 entry gone", 20'h12345);
        expect_miss("R9 second entry gone", 20'h0BEEF);
        expect_miss("R9 refill dropped", 20'h0C0DE);
    endtask

    task automatic t_evict();
        for (int i = 0; i < 64; i++) refill(20'h00200 + 20'(i), 20'h00300 + 20'(i));
        expect_hit("R8 first slot filled", 20'h00200, 12'h004, 1'b0, 20'h00300, 1'b0);
        expect_hit("R8 last slot filled", 20'h0023F, 12'h008, 1'b0, 20'h0033F, 1'b0);
        refill(20'h04000, 20'h00005);
        expect_miss("R8 slot 0 evicted", 20'h00200);
        expect_hit("R8 slot 1 kept", 20'h00201, 12'h00C, 1'b0, 20'h00301, 1'b0);
        expect_hit("R8 new in slot 0", 20'h04000, 12'h00C, 1'b0, 20'h00005, 1'b0);
        refill(20'h04001, 20'h00006);
        expect_miss("R8 slot 1 evicted", 20'h00201);
        expect_hit("R8 slot 2 kept", 20'h00202, 12'h010, 1'b0, 20'h00302, 1'b0);
        for (int k = 0; k < 62; k++) refill(20'h04100 + 20'(k), 20'h00400 + 20'(k));
        refill(20'h05000, 20'h00009);
        expect_miss("R8 wrap evicts slot 0", 20'h04000);
        expect_hit("R8 slot 1 after wrap", 20'h04001, 12'h014, 1'b0, 20'h00006, 1'b0);
        refill(20'h04001, 20'h00AAA);
        expect_hit("R7 present page reused", 20'h04001, 12'h018, 1'b0, 20'h00AAA, 1'b0);
        expect_hit("R7 no eviction", 20'h05000, 12'h01C, 1'b0, 20'h00009, 1'b0);
        expect_hit("R8 pointer slot kept", 20'h04100, 12'h020, 1'b0, 20'h00400, 1'b0);
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_dirty();
        t_same_cycle();
        t_overwrite();
        t_race();
        t_flush();
        t_evict();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule